// File: doc/BRIEF.md
# Folding Converter Code Combiner

This block forms the digital back end of a 6-bit folding-and-interpolating analog-to-digital converter. It takes two comparator banks as input. The first is a coarse bank of three comparators whose thermometer word selects one of four folds. The second is a fine bank of sixteen comparators whose word is a cyclic thermometer: the pattern runs upward inside even folds and is mirrored (bitwise complemented) inside odd folds.

The coarse word settles earlier than the fine word, so the block encodes the coarse word to two bits and passes it through a parameterised register delay. The fine word of the same sample arrives that many cycles later, and at that point the two are paired. The aligned coarse LSB decides whether the fine word is complemented, which restores an ordinary thermometer code. That code is encoded to four bits, concatenated under the coarse bits, and registered with a valid flag. The user selects one of two encoder variants by parameter: an edge-detect encoder with an OR tree, or a ones counter.

Top module: `fadc_code_combiner`

## Requirements
- R1: While `rst` is high, at the next rising edge `out_vld` goes to 0 and `out_code` goes to 0.
- R2: The coarse word has bit i set exactly when the fold index is greater than i (i = 0..2). The fold index (0..3) appears on `out_code[5:4]`.
- R3: Let f be the position inside the fold (0..15). In even folds, fine word bit j is 1 exactly when j < f. In odd folds the fine word is the complement of that pattern. In both cases `out_code[3:0]` equals f. For any fine word that is a clean thermometer after correction, the low output bits equal its count of ones, modulo 16.
- R4: A sample's coarse word is presented COARSE_DLY cycles (default 1) before its fine word. The output combines the two, and a different coarse word present on the fine word's own cycle has no effect.
- R5: A sample presented with `fine_vld` high appears on `out_code` with `out_vld` high one cycle later.
- R6: In a cycle after `fine_vld` was low, `out_vld` is 0 and `out_code` keeps its previous value.
- R7: Applying levels 0 to 63 in ascending order yields output codes that rise by exactly one per sample, from 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coarse_therm | input | 3 | Coarse comparator thermometer word |
| fine_word | input | 16 | Fine comparator cyclic thermometer word |
| fine_vld | input | 1 | Fine word carries a sample this cycle |
| out_code | output | 6 | Combined binary code, fold index in the top two bits |
| out_vld | output | 1 | `out_code` was updated this cycle |

## Verification
The bench builds the block with its default parameters: four fine bits, two coarse bits, a one-stage coarse delay and the edge-detect encoder. At this size all 64 levels fit into a single exhaustive sweep. Each level is applied in ascending, descending and scrambled order, so both inversion polarities and every fold boundary are exercised in consecutive cycles. Isolated samples, in which a conflicting coarse word sits on the fine word's cycle, show that the one-stage alignment pairs each fine word with the correct fold.

// File: rtl/fadc_pkg.sv
package fadc_pkg;
   // Encoder variant for thermometer-to-binary conversion
   typedef enum logic [0:0] {
      ENC_EDGE_TREE = 1'b0,
      ENC_ONES_CNT  = 1'b1
   } enc_style_e;
endpackage

// File: rtl/fadc_therm_enc.sv
module fadc_therm_enc
   import fadc_pkg::*;
#(
   parameter int         N     = 15,
   parameter int         B     = 4,
   parameter enc_style_e STYLE = ENC_EDGE_TREE
) (
   input  logic [N-1:0] therm,
   output logic [B-1:0] bin
);
   // number of edge positions the output width can name
   localparam int POS  = 1 << B;
   localparam int EN   = (N + 1 < POS) ? N + 1 : POS;
   localparam int CW   = $clog2(N + 2);

   if (N < 1) begin : g_bad_n
      $error("fadc_therm_enc: N must be at least 1");
   end
   if (B < 1) begin : g_bad_b
      $error("fadc_therm_enc: B must be at least 1");
   end

   if (STYLE == ENC_EDGE_TREE) begin : g_edge
      logic [EN-1:0] edge_oh;

      // one-hot marker at the top of the run of ones
      always_comb begin
         for (int j = 0; j < EN; j++) begin
            logic lo;
            logic hi;
            lo = (j == 0) ? 1'b1 : therm[j-1];
            hi = (j >= N) ? 1'b0 : therm[j];
            edge_oh[j] = lo & ~hi;
         end
      end

      // each output bit is an OR over the markers whose index has that bit
      for (genvar b = 0; b < B; b++) begin : g_bit
         always_comb begin
            bin[b] = 1'b0;
            for (int j = 0; j < EN; j++) begin
               if (((j >> b) & 1) != 0) begin
                  bin[b] = bin[b] | edge_oh[j];
               end
            end
         end
      end
   end else begin : g_cnt
      logic [CW-1:0] cnt;

      always_comb begin
         cnt = '0;
         for (int j = 0; j < N; j++) begin
            cnt = cnt + CW'(therm[j]);
         end
      end

      if (CW >= B) begin : g_trunc
         assign bin = cnt[B-1:0];
      end else begin : g_ext
         assign bin = B'(cnt);
      end
   end
endmodule

// File: rtl/fadc_coarse_align.sv
module fadc_coarse_align #(
   parameter int W   = 2,
   parameter int DLY = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DLY < 0) begin : g_bad_dly
      $error("fadc_coarse_align: DLY must not be negative");
   end

   if (DLY == 0) begin : g_pass
      assign q = d;
   end else begin : g_pipe
      logic [W-1:0] stg [DLY];

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < DLY; i++) begin
               stg[i] <= '0;
            end
         end else begin
            stg[0] <= d;
            for (int i = 1; i < DLY; i++) begin
               stg[i] <= stg[i-1];
            end
         end
      end

      assign q = stg[DLY-1];
   end
endmodule

// File: rtl/fadc_fold_fix.sv
module fadc_fold_fix #(
   parameter int N = 16
) (
   input  logic [N-1:0] raw,
   input  logic         odd_fold,
   output logic [N-1:0] fixed
);
   // mirrored folds present the complemented pattern
   for (genvar j = 0; j < N; j++) begin : g_bit
      assign fixed[j] = raw[j] ^ odd_fold;
   end
endmodule

// File: rtl/fadc_code_combiner.sv
module fadc_code_combiner
   import fadc_pkg::*;
#(
   parameter int         FINE_BITS   = 4,
   parameter int         COARSE_BITS = 2,
   parameter int         COARSE_DLY  = 1,
   parameter enc_style_e ENC_STYLE   = ENC_EDGE_TREE
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic [(1 << COARSE_BITS) - 2:0]       coarse_therm,
   input  logic [(1 << FINE_BITS) - 1:0]         fine_word,
   input  logic                                  fine_vld,
   output logic [FINE_BITS + COARSE_BITS - 1:0]  out_code,
   output logic                                  out_vld
);
   localparam int FINE_N   = 1 << FINE_BITS;
   localparam int COARSE_N = (1 << COARSE_BITS) - 1;
   localparam int OUT_W    = FINE_BITS + COARSE_BITS;

   if (FINE_BITS < 1 || FINE_BITS > 8) begin : g_bad_fine
      $error("fadc_code_combiner: FINE_BITS out of range 1..8");
   end
   if (COARSE_BITS < 1 || COARSE_BITS > 6) begin : g_bad_coarse
      $error("fadc_code_combiner: COARSE_BITS out of range 1..6");
   end
   if (COARSE_DLY < 0 || COARSE_DLY > 16) begin : g_bad_dly
      $error("fadc_code_combiner: COARSE_DLY out of range 0..16");
   end

   logic [COARSE_BITS-1:0] coarse_bin;
   logic [COARSE_BITS-1:0] coarse_al;
   logic [FINE_N-1:0]      fine_fixed;
   logic [FINE_BITS-1:0]   fine_bin;

   fadc_therm_enc #(
      .N     (COARSE_N),
      .B     (COARSE_BITS),
      .STYLE (ENC_STYLE)
   ) u_coarse_enc (
      .therm (coarse_therm),
      .bin   (coarse_bin)
   );

   fadc_coarse_align #(
      .W   (COARSE_BITS),
      .DLY (COARSE_DLY)
   ) u_align (
      .clk (clk),
      .rst (rst),
      .d   (coarse_bin),
      .q   (coarse_al)
   );

   fadc_fold_fix #(
      .N (FINE_N)
   ) u_fix (
      .raw      (fine_word),
      .odd_fold (coarse_al[0]),
      .fixed    (fine_fixed)
   );

   fadc_therm_enc #(
      .N     (FINE_N),
      .B     (FINE_BITS),
      .STYLE (ENC_STYLE)
   ) u_fine_enc (
      .therm (fine_fixed),
      .bin   (fine_bin)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_code <= '0;
         out_vld  <= 1'b0;
      end else begin
         out_vld <= fine_vld;
         if (fine_vld) begin
            out_code <= OUT_W'({coarse_al, fine_bin});
         end
      end
   end
endmodule

// File: rtl/fadc_code_combiner_chk.sv
module fadc_code_combiner_chk #(
   parameter int FINE_BITS   = 4,
   parameter int COARSE_BITS = 2
) (
   input logic                                 clk,
   input logic                                 rst,
   input logic                                 fine_vld,
   input logic                                 out_vld,
   input logic [FINE_BITS + COARSE_BITS - 1:0] out_code,
   input logic [(1 << FINE_BITS) - 1:0]        fix_word
);
   localparam int FINE_N = 1 << FINE_BITS;

   logic        is_therm;
   logic [31:0] ones_now;

   assign is_therm = ((fix_word & (fix_word + FINE_N'(1))) == '0);
   assign ones_now = 32'($countones(fix_word));

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!out_vld && out_code == '0));

   assert_fine_count_R3: assert property (@(posedge clk) disable iff (rst)
      (fine_vld && is_therm) |=>
         (out_code[FINE_BITS-1:0] == $past(ones_now[FINE_BITS-1:0])));

   assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
      fine_vld |=> out_vld);

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !fine_vld |=> (!out_vld && $stable(out_code)));
endmodule

bind fadc_code_combiner fadc_code_combiner_chk #(
   .FINE_BITS   (FINE_BITS),
   .COARSE_BITS (COARSE_BITS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .fine_vld (fine_vld),
   .out_vld  (out_vld),
   .out_code (out_code),
   .fix_word (fine_fixed)
);

// File: tb/fadc_code_combiner_tb.sv
module fadc_code_combiner_tb;
   localparam int FB  = 4;
   localparam int CB  = 2;
   localparam int DLY = 1;
   localparam int FN  = 1 << FB;
   localparam int CN  = (1 << CB) - 1;
   localparam int NL  = 1 << (FB + CB);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [CN-1:0] coarse_therm = '0;
   logic [FN-1:0] fine_word = '0;
   logic          fine_vld = 1'b0;
   logic [FB+CB-1:0] out_code;
   logic          out_vld;

   int nchk = 0;
   int nfail = 0;
   int exp_q[$];
   bit mono_on = 1'b0;
   int prev_code = -1;
   int last_code = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fadc_code_combiner #(
      .FINE_BITS   (FB),
      .COARSE_BITS (CB),
      .COARSE_DLY  (DLY)
   ) u_dut (
      .clk          (clk),
      .rst          (rst),
      .coarse_therm (coarse_therm),
      .fine_word    (fine_word),
      .fine_vld     (fine_vld),
      .out_code     (out_code),
      .out_vld      (out_vld)
   );

   function automatic logic [CN-1:0] therm_of(input int fold);
      logic [CN-1:0] t;
      for (int i = 0; i < CN; i++) t[i] = (fold > i);
      return t;
   endfunction

   function automatic logic [FN-1:0] fine_of(input int level);
      logic [FN-1:0] t;
      int f;
      f = level % FN;
      for (int j = 0; j < FN; j++) t[j] = (j < f);
      if (((level / FN) % 2) == 1) t = ~t;
      return t;
   endfunction

   function automatic int level_of(input int mode, input int i);
      if (mode == 0) return i;
      if (mode == 1) return NL - 1 - i;
      return (i * 37 + 11) % NL;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops expected codes as results appear
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_vld) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected out_vld", int'(out_code), -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               // high bits: fold (R2, alignment R4); low bits: position (R3)
               check(int'(out_code[FB+CB-1:FB]) == e / FN, "R2/R4 fold bits",
                     int'(out_code[FB+CB-1:FB]), e / FN);
               check(int'(out_code[FB-1:0]) == e % FN, "R3 fine bits",
                     int'(out_code[FB-1:0]), e % FN);
               if (mono_on) begin
                  check(int'(out_code) == prev_code + 1, "R7 monotonic step",
                        int'(out_code), prev_code + 1);
                  prev_code = int'(out_code);
               end
            end
            last_code = int'(out_code);
         end else begin
            check(int'(out_code) == last_code, "R6 hold while idle",
                  int'(out_code), last_code);
         end
      end
   end

   // stream: coarse of a level leads its fine word by DLY cycles
   task automatic run_stream(input int mode);
      for (int k = 0; k < NL + DLY; k++) begin
         @(negedge clk);
         coarse_therm = (k < NL) ? therm_of(level_of(mode, k) / FN) : '0;
         if (k >= DLY) begin
            fine_word = fine_of(level_of(mode, k - DLY));
            fine_vld  = 1'b1;
            exp_q.push_back(level_of(mode, k - DLY));
         end else begin
            fine_vld = 1'b0;
         end
      end
      @(negedge clk);
      fine_vld = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // isolated sample with a conflicting coarse word on the fine cycle (R4)
   task automatic send_isolated(input int level);
      @(negedge clk);
      coarse_therm = therm_of(level / FN);
      if (DLY == 0) begin
         fine_word = fine_of(level);
         fine_vld  = 1'b1;
         exp_q.push_back(level);
      end else begin
         fine_vld = 1'b0;
         for (int d = 0; d < DLY; d++) begin
            @(negedge clk);
            coarse_therm = therm_of(CN - level / FN);
            if (d == DLY - 1) begin
               fine_word = fine_of(level);
               fine_vld  = 1'b1;
               exp_q.push_back(level);
            end
         end
      end
      @(negedge clk);
      fine_vld     = 1'b0;
      coarse_therm = '0;
      fine_word    = '1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
      check(out_code == '0, "R1 out_code in reset", int'(out_code), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      // R7: ascending sweep with monotonic check
      prev_code = -1;
      mono_on   = 1'b1;
      run_stream(0);
      mono_on   = 1'b0;
      check(prev_code == NL - 1, "R7 sweep reached top", prev_code, NL - 1);

      run_stream(1);
      run_stream(2);

      send_isolated(0);
      send_isolated(15);
      send_isolated(16);
      send_isolated(31);
      send_isolated(32);
      send_isolated(47);
      send_isolated(48);
      send_isolated(63);

      check(exp_q.size() == 0, "R5 all samples emerged", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule